// File: doc/BRIEF.md
# Configurable AND-OR logic array

This block is the programmable sum-of-products core of a small logic device. Twenty-two array signals (dedicated inputs together with the ten feedback or pin signals that the surrounding macrocells return) form true and inverted literals. Every product term ANDs whichever literals its fuse row connects. Ten output sums each OR a private group of product terms, and the group sizes differ from output to output. Beside the sums, the array produces one output-enable term per output, plus two terms shared by all outputs: an asynchronous reset term and a synchronous preset term. The macrocells that consume these signals lie outside this block.

The fuse rows are loaded through a row-wide write port. The port accepts writes only while the program-mode input is high, and all array outputs are forced low for as long as that input stays high. When program mode drops, the outputs follow the array inputs combinationally, with no clock involved.

Top module: `pla_array`

## Requirements
- R1: With program mode low, sumOut[k] is the OR of the product terms of output k. The term counts for outputs 0 to 9 are 8, 10, 12, 14, 16, 16, 14, 12, 10, 8. The rows of output k follow directly after those of output k-1, and output 0 starts at row 0, so the sum rows are rows 0 to 119.
- R2: Within a fuse row, bit 2i connects the true literal of arrayIn[i] and bit 2i+1 connects its complement. A term is the AND of every connected literal.
- R3: A term that connects both literals of the same input is false for every input pattern.
- R4: A row with no bit set is false when it is a sum, reset or preset term. It is true when it is an output-enable term.
- R5: oeOut[k] is the term held in row 120+k.
- R6: arstOut is the term held in row 130, and spreOut is the term held in row 131.
- R7: While progMode is high, every bit of sumOut and oeOut, and both arstOut and spreOut, are 0.
- R8: With progMode and wrEn both high and wrAddr below 132, the rising clock edge loads wrData into row wrAddr. The new row is reflected in the outputs as soon as progMode is low again.
- R9: No row changes when progMode is low, when wrEn is low, or when wrAddr is 132 or above.
- R10: An active-low rst_n clears every fuse row. After reset, every sum is 0, every enable is 1, and the reset and preset terms are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for fuse writes |
| rst_n | input | 1 | Asynchronous active-low reset that clears all fuses |
| progMode | input | 1 | Program mode: enables writes and forces outputs low |
| wrEn | input | 1 | Row write strobe |
| wrAddr | input | 8 | Fuse row index, 0 to 131 |
| wrData | input | 44 | Fuse row contents, two bits per array input |
| arrayIn | input | 22 | Array input signals, including feedback |
| sumOut | output | 10 | Output sums |
| oeOut | output | 10 | Per-output enable terms |
| arstOut | output | 1 | Shared asynchronous reset term |
| spreOut | output | 1 | Shared synchronous preset term |

## Verification
A sweep over all 132 rows places one literal in one row at a time, alternating polarity, and applies inputs with that bit low, high, all zeros and all ones. This shows whether each row reaches the right output, and the correct output only. Short exhaustive sweeps over the few bits that a multi-literal term or a conflicting term looks at, with random values on the other bits, separate correct AND behaviour from polarity swaps, dropped literals and terms that a contradiction fails to kill. A random sparse configuration of every row, driven with a few hundred random input words, tests the OR grouping across outputs of unequal size. Writes outside program mode, with the strobe low, and at the first and last invalid addresses are each followed by an input sweep, which catches any row they touch.

// File: rtl/pla_pkg.sv
package pla_pkg;

  localparam int NumIn    = 22;
  localparam int NumOut   = 10;
  localparam int MinTerms = 8;
  localparam int TermStep = 2;

  localparam int RowBits = 2 * NumIn;

  // Output k and output NumOut-1-k share a term budget: counts rise to the
  // centre and fall back.
  function automatic int termCount(input int k);
    int pairIdx;
    pairIdx = (k < NumOut / 2) ? k : (NumOut - 1 - k);
    return MinTerms + TermStep * pairIdx;
  endfunction

  function automatic int termBase(input int k);
    int base;
    base = 0;
    for (int j = 0; j < k; j++) base += termCount(j);
    return base;
  endfunction

  localparam int NumSumRows = termBase(NumOut);
  localparam int OeRowBase  = NumSumRows;
  localparam int ArstRow    = OeRowBase + NumOut;
  localparam int SpreRow    = ArstRow + 1;
  localparam int NumRows    = SpreRow + 1;
  localparam int RowAddrW   = $clog2(NumRows);

  typedef struct packed {
    logic                rowWe;
    logic [RowAddrW-1:0] rowSel;
    logic                holdOut;
  } ctrlStrobe_t;

endpackage

// File: rtl/pla_ctrl.sv
module pla_ctrl
  import pla_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                progMode,
  input  logic                wrEn,
  input  logic [RowAddrW-1:0] wrAddr,
  output ctrlStrobe_t         strobe
);

  localparam logic [RowAddrW-1:0] LastRow = RowAddrW'(NumRows - 1);

  logic addrOk;

  assign addrOk = (wrAddr <= LastRow);

  always_comb begin
    strobe.rowWe   = progMode & wrEn & addrOk;
    strobe.rowSel  = wrAddr;
    strobe.holdOut = progMode;
  end

  // R9
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrAddr > LastRow) |-> !strobe.rowWe);

  // R9
  run_mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!progMode || !wrEn) |-> !strobe.rowWe);

endmodule

// File: rtl/pla_term.sv
module pla_term #(
  parameter int NumIn     = 22,
  parameter bit EmptyTrue = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [2*NumIn-1:0] wrData,
  input  logic [NumIn-1:0]   arrayIn,
  output logic               termOut
);

  logic [2*NumIn-1:0] fuseRow;
  logic [NumIn-1:0]   trueSel;
  logic [NumIn-1:0]   compSel;
  logic [NumIn-1:0]   blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fuseRow <= '0;
    else if (we) fuseRow <= wrData;
  end

  always_comb begin
    for (int i = 0; i < NumIn; i++) begin
      trueSel[i] = fuseRow[2*i];
      compSel[i] = fuseRow[2*i+1];
    end
  end

  // A literal blocks the term when its input sits at the wrong level.
  assign blocked = (trueSel & ~arrayIn) | (compSel & arrayIn);
  assign termOut = (|fuseRow) ? ~(|blocked) : EmptyTrue;

  // R9
  fuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(fuseRow));

  // R8
  fuse_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (fuseRow == $past(wrData)));

  // R3
  conflict_false_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(trueSel & compSel)) |-> !termOut);

endmodule

// File: rtl/pla_datapath.sv
module pla_datapath
  import pla_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrobe_t        strobe,
  input  logic [RowBits-1:0] wrData,
  input  logic [NumIn-1:0]   arrayIn,
  output logic [NumOut-1:0]  sumOut,
  output logic [NumOut-1:0]  oeOut,
  output logic               arstOut,
  output logic               spreOut
);

  logic [NumRows-1:0] termVec;
  logic [NumRows-1:0] weVec;
  logic [NumOut-1:0]  rawSum;
  logic [NumOut-1:0]  rawOe;

  for (genvar r = 0; r < NumRows; r++) begin : g_row
    localparam bit IsOe = (r >= OeRowBase) && (r < ArstRow);

    assign weVec[r] = strobe.rowWe && (strobe.rowSel == RowAddrW'(r));

    pla_term #(
      .NumIn    (NumIn),
      .EmptyTrue(IsOe)
    ) u_term (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (weVec[r]),
      .wrData (wrData),
      .arrayIn(arrayIn),
      .termOut(termVec[r])
    );
  end

  for (genvar k = 0; k < NumOut; k++) begin : g_sum
    localparam int Base = termBase(k);
    localparam int Cnt  = termCount(k);
    assign rawSum[k] = |termVec[Base +: Cnt];
  end

  assign rawOe = termVec[OeRowBase +: NumOut];

  always_comb begin
    if (strobe.holdOut) begin
      sumOut  = '0;
      oeOut   = '0;
      arstOut = 1'b0;
      spreOut = 1'b0;
    end else begin
      sumOut  = rawSum;
      oeOut   = rawOe;
      arstOut = termVec[ArstRow];
      spreOut = termVec[SpreRow];
    end
  end

  // R8
  single_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(weVec));

endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                progMode,
  input  logic                wrEn,
  input  logic [RowAddrW-1:0] wrAddr,
  input  logic [RowBits-1:0]  wrData,
  input  logic [NumIn-1:0]    arrayIn,
  output logic [NumOut-1:0]   sumOut,
  output logic [NumOut-1:0]   oeOut,
  output logic                arstOut,
  output logic                spreOut
);

  ctrlStrobe_t strobe;

  pla_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .progMode(progMode),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .strobe  (strobe)
  );

  pla_datapath u_datapath (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .wrData (wrData),
    .arrayIn(arrayIn),
    .sumOut (sumOut),
    .oeOut  (oeOut),
    .arstOut(arstOut),
    .spreOut(spreOut)
  );

  // R7
  prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    progMode |-> ((sumOut == '0) && (oeOut == '0) && !arstOut && !spreOut));

endmodule

// File: tb/test_pla_array.sv
module test_pla_array;

  localparam int NIn   = 22;
  localparam int NOut  = 10;
  localparam int NRows = 132;
  localparam int RW    = 44;

  logic            clk      = 1'b0;
  logic            rst_n    = 1'b0;
  logic            progMode = 1'b0;
  logic            wrEn     = 1'b0;
  logic [7:0]      wrAddr   = '0;
  logic [RW-1:0]   wrData   = '0;
  logic [NIn-1:0]  arrayIn  = '0;
  logic [NOut-1:0] sumOut;
  logic [NOut-1:0] oeOut;
  logic            arstOut;
  logic            spreOut;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [RW-1:0] mdl [NRows];
  logic [31:0]   seed = 32'h1234_5678;

  always #5 clk = ~clk;

  pla_array i_pla_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .progMode(progMode),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .arrayIn (arrayIn),
    .sumOut  (sumOut),
    .oeOut   (oeOut),
    .arstOut (arstOut),
    .spreOut (spreOut)
  );

  function automatic logic [31:0] nextRand();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  // Term budget per output, from R1.
  function automatic int cntOf(input int k);
    return 8 + 2 * ((k < 5) ? k : (9 - k));
  endfunction

  // Term value from R2, R3 and R4.
  function automatic bit termVal(input int r, input logic [NIn-1:0] x, input bit emptyTrue);
    if (mdl[r] == '0) return emptyTrue;
    for (int i = 0; i < NIn; i++) begin
      if (mdl[r][2*i] && !x[i]) return 1'b0;
      if (mdl[r][2*i+1] && x[i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic checkOut(input string tag);
    logic [NOut-1:0] eSum;
    logic [NOut-1:0] eOe;
    bit eA;
    bit eS;
    int row;
    row  = 0;
    eSum = '0;
    for (int k = 0; k < NOut; k++) begin
      for (int j = 0; j < cntOf(k); j++) begin
        eSum[k] = eSum[k] | termVal(row, arrayIn, 1'b0);
        row++;
      end
    end
    for (int k = 0; k < NOut; k++) eOe[k] = termVal(120 + k, arrayIn, 1'b1);
    eA = termVal(130, arrayIn, 1'b0);
    eS = termVal(131, arrayIn, 1'b0);
    if (progMode) begin
      eSum = '0;
      eOe  = '0;
      eA   = 1'b0;
      eS   = 1'b0;
    end
    checks++;
    if ({sumOut, oeOut, arstOut, spreOut} !== {eSum, eOe, eA, eS}) begin
      errors++;
      $display("FAIL %s in=%h sum=%h exp %h oe=%h exp %h rst=%b exp %b pre=%b exp %b",
               tag, arrayIn, sumOut, eSum, oeOut, eOe, arstOut, eA, spreOut, eS);
    end
  endtask

  task automatic applyIn(input logic [NIn-1:0] x, input string tag);
    @(negedge clk);
    arrayIn = x;
    #2;
    checkOut(tag);
  endtask

  task automatic writeRow(input bit pm, input bit we, input logic [7:0] addr, input logic [RW-1:0] data);
    @(negedge clk);
    progMode = pm;
    wrEn     = we;
    wrAddr   = addr;
    wrData   = data;
    if (pm && we && (addr < NRows)) mdl[addr] = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setMode(input bit pm);
    @(negedge clk);
    progMode = pm;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int r = 0; r < NRows; r++) mdl[r] = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_900_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NRows; r++) mdl[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 and R4: cleared fuses give sums 0, enables 1, shared terms 0.
    applyIn('0, "R10 reset zeros");
    applyIn('1, "R10 reset ones");
    applyIn(22'h2A_AAAA, "R4 empty rows");
    applyIn(nextRand()[NIn-1:0], "R4 empty rows random");

    // R1 R2 R5 R6 R8: one literal per row, alternating polarity.
    for (int r = 0; r < NRows; r++) begin
      int i;
      int pol;
      string tag;
      i   = r % NIn;
      pol = (r / NIn) % 2;
      if (r < 120) tag = $sformatf("R1 row %0d", r);
      else if (r < 130) tag = $sformatf("R5 row %0d", r);
      else tag = $sformatf("R6 row %0d", r);
      writeRow(1'b1, 1'b1, 8'(r), RW'(1) << (2 * i + pol));
      if (r % 11 == 0) begin
        applyIn(NIn'(1) << i, "R7 outputs held in program mode");
        applyIn(~(NIn'(1) << i), "R7 outputs held in program mode");
      end
      setMode(1'b0);
      applyIn('0, tag);
      applyIn(NIn'(1) << i, tag);
      applyIn('1, tag);
      applyIn(~(NIn'(1) << i), tag);
      writeRow(1'b1, 1'b1, 8'(r), '0);
    end

    // R3: both literals of one input in a sum row and an enable row.
    writeRow(1'b1, 1'b1, 8'd0, (RW'(1) << 6) | (RW'(1) << 7) | RW'(1));
    writeRow(1'b1, 1'b1, 8'd121, (RW'(1) << 10) | (RW'(1) << 11));
    setMode(1'b0);
    for (int v = 0; v < 64; v++) begin
      logic [NIn-1:0] x;
      x = (nextRand()[NIn-1:0] & ~NIn'(63)) | NIn'(v);
      applyIn(x, "R3 conflicting literals");
    end
    writeRow(1'b1, 1'b1, 8'd0, '0);
    writeRow(1'b1, 1'b1, 8'd121, '0);

    // R2: row 20 (output 2) = in0 & ~in1 & in21; row 21 (output 2) = in5.
    writeRow(1'b1, 1'b1, 8'd20, (RW'(1) << 0) | (RW'(1) << 3) | (RW'(1) << 42));
    writeRow(1'b1, 1'b1, 8'd21, RW'(1) << 10);
    setMode(1'b0);
    for (int v = 0; v < 16; v++) begin
      logic [NIn-1:0] x;
      x     = nextRand()[NIn-1:0];
      x[0]  = v[0];
      x[1]  = v[1];
      x[21] = v[2];
      x[5]  = v[3];
      applyIn(x, "R2 multi-literal AND");
    end

    // R9: ignored writes, then the same sweep must match the unchanged rows.
    writeRow(1'b0, 1'b1, 8'd20, '1);
    writeRow(1'b1, 1'b0, 8'd21, '1);
    writeRow(1'b1, 1'b1, 8'd132, '1);
    writeRow(1'b1, 1'b1, 8'd255, '1);
    setMode(1'b0);
    for (int v = 0; v < 16; v++) begin
      logic [NIn-1:0] x;
      x     = nextRand()[NIn-1:0];
      x[0]  = v[0];
      x[1]  = v[1];
      x[21] = v[2];
      x[5]  = v[3];
      applyIn(x, "R9 ignored writes");
    end

    // R1: random sparse configuration of every row.
    for (int r = 0; r < NRows; r++) begin
      logic [RW-1:0] d;
      d = '0;
      if (nextRand()[0]) begin
        int a;
        int b;
        a = int'(nextRand() % 22);
        b = int'(nextRand() % 22);
        d[2*a + int'(nextRand() % 2)] = 1'b1;
        d[2*b + int'(nextRand() % 2)] = 1'b1;
      end
      writeRow(1'b1, 1'b1, 8'(r), d);
    end
    applyIn(nextRand()[NIn-1:0], "R7 held after full load");
    setMode(1'b0);
    repeat (300) applyIn(nextRand()[NIn-1:0], "R1 random configuration");

    // R10: reset mid-run clears the loaded configuration.
    doReset();
    repeat (8) applyIn(nextRand()[NIn-1:0], "R10 reset after load");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule